// File: doc/BRIEF.md
# Unlockable Extension Register Bank

This block keeps a set of extension configuration registers behind an indexed host port, together with a small file of standard horizontal timing registers reached through a second indexed port. The extension port stays closed after reset. Software opens it by writing a key byte to the key register and closes it with a second key byte. While the port is closed, only the key register and the write-protect alias register respond. Reading the key register gives a single status bit, not the byte that was written.

The bank also drives a few side controls. It can force the index/data phase flip-flop of an attribute-style port, and it holds that port's index and a video-enable bit. It holds two address offsets and a page-control field whose writes can be locked. It keeps a bit that write-protects the standard timing registers. That bit has two homes: one on the standard path and one on the extension path, and the extension copy can always be reached. A working copy of the horizontal timing registers goes to downstream logic. A select bit decides whether this copy follows standard-path writes or changes only through extension-path writes.

Every read is registered: read data shows the addressed value one clock after the read strobe. Writes take effect on the clock edge that samples the write strobe.

Top module: `extbank_top`

## Requirements
- R1: Writing 0xEC to extension index 0x0A opens the extension port and writing 0xCE closes it. Any other byte written there leaves the port state unchanged.
- R2: A read of index 0x0A returns 0x01 while the port is open and 0x00 while it is closed. Bits 7:1 of that read are always zero.
- R3: While the port is closed, extension writes to any index other than 0x0A and 0x0C change nothing, and extension reads of those indices return 0x00. Values stored before the port closed are still there when it opens again.
- R4: Index 0x0B holds three fields. Bit 7 is the attribute phase flip-flop (0 = index phase, 1 = data phase): a read returns its state and a write forces it. Bit 5 is video enable. Bits 4:0 are the attribute index. Bit 6 reads as zero. A pulse on `attrToggle` inverts the flip-flop.
- R5: Bit 7 of index 0x0C and bit 7 of standard register 0x11 are the same storage bit. Index 0x0C can be read and written at every moment, even while the port is closed. Its bits 6:0 read as zero.
- R6: When bit 7 of standard register 0x11 and bit 7 of standard register 0x03 are both 1, standard writes to indices 0x00..0x07 are ignored. When bit 7 of register 0x11 is 1, bit 7 of register 0x03 cannot be changed. Standard register 0x11 can be written and read only while bit 7 of register 0x03 is 1; otherwise it reads as 0x00.
- R7: Bits 2:0 of index 0x0D drive `pageCtl`. Writes to 0x0D are ignored while bit 4 of the lock register at index 0x20 is 1.
- R8: Bit 0 of index 0x21 selects the write path for the working copy. When it is 0, a standard write to register n (n below NUM_SHADOW) also updates working copy n. When it is 1, working copy n changes only through extension writes to index 0x60+n. A working copy can always be read at index 0x60+n.
- R9: Reset clears every register except the attribute index bits. Extension and standard reads return data one clock after the strobe. Unmapped indices read as 0x00.
- R10: Indices 0x0E and 0x0F hold two 8-bit address offsets. Each reads back what was written and drives `mapOffsetA` or `mapOffsetB`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extWr | input | 1 | Extension write strobe |
| extRd | input | 1 | Extension read strobe |
| extIdx | input | 8 | Extension register index |
| extWdata | input | 8 | Extension write data |
| extRdata | output | 8 | Extension read data, valid one clock after extRd |
| stdWr | input | 1 | Standard-path write strobe |
| stdRd | input | 1 | Standard-path read strobe |
| stdIdx | input | 8 | Standard register index |
| stdWdata | input | 8 | Standard write data |
| stdRdata | output | 8 | Standard read data, valid one clock after stdRd |
| attrToggle | input | 1 | Inverts the attribute phase flip-flop |
| attrDataPhase | output | 1 | Attribute phase flip-flop (1 = data) |
| attrIndex | output | 5 | Attribute index |
| videoEnable | output | 1 | Video enable |
| pageCtl | output | 3 | Page control field |
| mapOffsetA | output | 8 | First address offset |
| mapOffsetB | output | 8 | Second address offset |
| hzWorking | output | NUM_SHADOW*8 | Working copy of the horizontal timing registers, copy n in bits 8n+7:8n |
| hzProtect | output | 1 | Write protection of standard registers 0x00..0x07 is in force |

## Verification
The assertions assume that the host never raises a write strobe and a read strobe on the same port in the same cycle. They also assume that `attrToggle` and an extension write to index 0x0B never arrive together. The stimulus keeps to both rules because every access runs alone in its own strobe cycle. The toggle input is pulsed only when both ports are idle. The protection assertions also assume that the select and lock bits change only through this block's own write ports, and the bench reaches them only that way.

// File: rtl/extbank_pkg.sv
package extbank_pkg;

  // extension-side indices
  localparam logic [7:0] IDX_KEY    = 8'h0A;
  localparam logic [7:0] IDX_ATTR   = 8'h0B;
  localparam logic [7:0] IDX_WPROT  = 8'h0C;
  localparam logic [7:0] IDX_PAGE   = 8'h0D;
  localparam logic [7:0] IDX_MAPA   = 8'h0E;
  localparam logic [7:0] IDX_MAPB   = 8'h0F;
  localparam logic [7:0] IDX_LOCK   = 8'h20;
  localparam logic [7:0] IDX_HSEL   = 8'h21;
  localparam logic [7:0] IDX_SHBASE = 8'h60;

  // standard-side indices
  localparam logic [7:0] IDX_STD_WP   = 8'h11;
  localparam logic [7:0] IDX_STD_GATE = 8'h03;
  localparam int         GATE_REG     = 3;

  // key bytes
  localparam logic [7:0] KEY_OPEN  = 8'hEC;
  localparam logic [7:0] KEY_CLOSE = 8'hCE;

  localparam int PAGE_LOCK_BIT = 4;

  typedef struct packed {
    logic keyOpen;
    logic keyClose;
    logic attrWr;
    logic wpWr;
    logic pageWr;
    logic mapAWr;
    logic mapBWr;
    logic lockWr;
    logic selWr;
    logic shExtWr;
    logic stdRegWr;
    logic stdKeepB7;
    logic stdShWr;
    logic stdWpWr;
    logic extRdOk;
    logic stdRdOk;
  } bankStrobe_t;

  typedef struct packed {
    logic unlocked;
    logic stdWpBit;
    logic cr3Top;
    logic pageLock;
    logic shadowSel;
  } bankStatus_t;

endpackage

// File: rtl/extbank_ctrl.sv
module extbank_ctrl
  import extbank_pkg::*;
#(
  parameter int NUM_STD    = 8,
  parameter int NUM_SHADOW = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        extWr,
  input  logic [7:0]  extIdx,
  input  logic [7:0]  extWdata,
  input  logic        stdWr,
  input  logic [7:0]  stdIdx,
  input  bankStatus_t status,
  output bankStrobe_t strobe
);

  localparam logic [8:0] SH_LIMIT = {1'b0, IDX_SHBASE} + 9'(NUM_SHADOW);

  logic hitKey, hitAttr, hitWp, hitPage, hitMapA, hitMapB, hitLock, hitSel, hitSh;
  logic stdIsCore, stdProtect, openPath;

  always_comb begin
    hitKey  = (extIdx == IDX_KEY);
    hitAttr = (extIdx == IDX_ATTR);
    hitWp   = (extIdx == IDX_WPROT);
    hitPage = (extIdx == IDX_PAGE);
    hitMapA = (extIdx == IDX_MAPA);
    hitMapB = (extIdx == IDX_MAPB);
    hitLock = (extIdx == IDX_LOCK);
    hitSel  = (extIdx == IDX_HSEL);
    hitSh   = ({1'b0, extIdx} >= {1'b0, IDX_SHBASE}) && ({1'b0, extIdx} < SH_LIMIT);
    openPath   = status.unlocked;
    stdIsCore  = (stdIdx < 8'(NUM_STD));
    stdProtect = status.stdWpBit && status.cr3Top;
  end

  always_comb begin
    strobe          = '0;
    strobe.keyOpen  = extWr && hitKey && (extWdata == KEY_OPEN);
    strobe.keyClose = extWr && hitKey && (extWdata == KEY_CLOSE);
    strobe.wpWr     = extWr && hitWp;
    strobe.attrWr   = extWr && openPath && hitAttr;
    strobe.pageWr   = extWr && openPath && hitPage && !status.pageLock;
    strobe.mapAWr   = extWr && openPath && hitMapA;
    strobe.mapBWr   = extWr && openPath && hitMapB;
    strobe.lockWr   = extWr && openPath && hitLock;
    strobe.selWr    = extWr && openPath && hitSel;
    strobe.shExtWr  = extWr && openPath && hitSh;
    strobe.stdRegWr = stdWr && stdIsCore && !stdProtect;
    strobe.stdKeepB7 = strobe.stdRegWr && (stdIdx == IDX_STD_GATE) && status.stdWpBit;
    strobe.stdShWr  = strobe.stdRegWr && !status.shadowSel && (stdIdx < 8'(NUM_SHADOW));
    strobe.stdWpWr  = stdWr && (stdIdx == IDX_STD_WP) && status.cr3Top;
    strobe.extRdOk  = openPath || hitKey || hitWp;
    strobe.stdRdOk  = stdIsCore || ((stdIdx == IDX_STD_WP) && status.cr3Top);
  end

  // R3: one extension write lands on at most one register target
  p_one_target_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.keyOpen, strobe.keyClose, strobe.wpWr, strobe.attrWr, strobe.pageWr,
              strobe.mapAWr, strobe.mapBWr, strobe.lockWr, strobe.selWr, strobe.shExtWr}));

  // R6: standard register 0x11 unreachable while register 0x03 bit 7 is clear
  p_wp_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stdWr && !status.cr3Top) |-> !strobe.stdWpWr);

endmodule

// File: rtl/extbank_dp.sv
module extbank_dp
  import extbank_pkg::*;
#(
  parameter int NUM_STD    = 8,
  parameter int NUM_SHADOW = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  bankStrobe_t             strobe,
  input  logic                    extRd,
  input  logic [7:0]              extIdx,
  input  logic [7:0]              extWdata,
  input  logic                    stdRd,
  input  logic [7:0]              stdIdx,
  input  logic [7:0]              stdWdata,
  input  logic                    attrToggle,
  output bankStatus_t             status,
  output logic [7:0]              extRdata,
  output logic [7:0]              stdRdata,
  output logic                    attrDataPhase,
  output logic [4:0]              attrIndex,
  output logic                    videoEnable,
  output logic [2:0]              pageCtl,
  output logic [7:0]              mapOffsetA,
  output logic [7:0]              mapOffsetB,
  output logic [NUM_SHADOW*8-1:0] hzWorking,
  output logic                    hzProtect
);

  localparam int STD_FLAT_W = NUM_STD * 8;

  logic       unlocked;
  logic       attrFlip;
  logic       videoEn;
  logic [4:0] attrIdx;
  logic [2:0] pageBits;
  logic [7:0] mapA, mapB, lockReg;
  logic       shadowSel;
  logic [7:0] cr11Reg;
  logic [7:0] stdRegs [NUM_STD];
  logic [7:0] shadow  [NUM_SHADOW];
  logic [STD_FLAT_W-1:0] stdFlat;
  logic [7:0] stdWrVal, extMux, stdMux;

  // key / port state
  always_ff @(posedge clk) begin
    if (!rstN)                unlocked <= 1'b0;
    else if (strobe.keyOpen)  unlocked <= 1'b1;
    else if (strobe.keyClose) unlocked <= 1'b0;
  end

  // attribute phase flip-flop and video enable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      attrFlip <= 1'b0;
      videoEn  <= 1'b0;
    end else if (strobe.attrWr) begin
      attrFlip <= extWdata[7];
      videoEn  <= extWdata[5];
    end else if (attrToggle) begin
      attrFlip <= ~attrFlip;
    end
  end

  // attribute index carries no reset value
  always_ff @(posedge clk) begin
    if (strobe.attrWr) attrIdx <= extWdata[4:0];
  end

  // plain extension registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageBits  <= '0;
      mapA      <= '0;
      mapB      <= '0;
      lockReg   <= '0;
      shadowSel <= 1'b0;
    end else begin
      if (strobe.pageWr) pageBits  <= extWdata[2:0];
      if (strobe.mapAWr) mapA      <= extWdata;
      if (strobe.mapBWr) mapB      <= extWdata;
      if (strobe.lockWr) lockReg   <= extWdata;
      if (strobe.selWr)  shadowSel <= extWdata[0];
    end
  end

  // standard register 0x11, bit 7 shared with extension index 0x0C
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cr11Reg <= '0;
    end else begin
      if (strobe.stdWpWr) cr11Reg[6:0] <= stdWdata[6:0];
      if (strobe.wpWr)         cr11Reg[7] <= extWdata[7];
      else if (strobe.stdWpWr) cr11Reg[7] <= stdWdata[7];
    end
  end

  assign stdWrVal = strobe.stdKeepB7 ? {stdRegs[GATE_REG][7], stdWdata[6:0]} : stdWdata;

  for (genvar g = 0; g < NUM_STD; g++) begin : g_std
    always_ff @(posedge clk) begin
      if (!rstN)                                       stdRegs[g] <= '0;
      else if (strobe.stdRegWr && stdIdx == 8'(g))     stdRegs[g] <= stdWrVal;
    end
    assign stdFlat[g*8 +: 8] = stdRegs[g];
  end

  for (genvar g = 0; g < NUM_SHADOW; g++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rstN)
        shadow[g] <= '0;
      else if (strobe.shExtWr && extIdx == IDX_SHBASE + 8'(g))
        shadow[g] <= extWdata;
      else if (strobe.stdShWr && stdIdx == 8'(g))
        shadow[g] <= stdWrVal;
    end
    assign hzWorking[g*8 +: 8] = shadow[g];
  end

  // read multiplexers
  always_comb begin
    extMux = '0;
    unique case (extIdx)
      IDX_KEY:   extMux = {7'b0, unlocked};
      IDX_ATTR:  extMux = {attrFlip, 1'b0, videoEn, attrIdx};
      IDX_WPROT: extMux = {cr11Reg[7], 7'b0};
      IDX_PAGE:  extMux = {5'b0, pageBits};
      IDX_MAPA:  extMux = mapA;
      IDX_MAPB:  extMux = mapB;
      IDX_LOCK:  extMux = lockReg;
      IDX_HSEL:  extMux = {7'b0, shadowSel};
      default: begin
        for (int i = 0; i < NUM_SHADOW; i++)
          if (extIdx == IDX_SHBASE + 8'(i)) extMux = shadow[i];
      end
    endcase
  end

  always_comb begin
    stdMux = '0;
    if (stdIdx == IDX_STD_WP) stdMux = cr11Reg;
    for (int i = 0; i < NUM_STD; i++)
      if (stdIdx == 8'(i)) stdMux = stdRegs[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extRdata <= '0;
      stdRdata <= '0;
    end else begin
      if (extRd) extRdata <= strobe.extRdOk ? extMux : 8'h00;
      if (stdRd) stdRdata <= strobe.stdRdOk ? stdMux : 8'h00;
    end
  end

  always_comb begin
    status.unlocked  = unlocked;
    status.stdWpBit  = cr11Reg[7];
    status.cr3Top    = stdRegs[GATE_REG][7];
    status.pageLock  = lockReg[PAGE_LOCK_BIT];
    status.shadowSel = shadowSel;
  end

  assign attrDataPhase = attrFlip;
  assign attrIndex     = attrIdx;
  assign videoEnable   = videoEn;
  assign pageCtl       = pageBits;
  assign mapOffsetA    = mapA;
  assign mapOffsetB    = mapB;
  assign hzProtect     = cr11Reg[7] & stdRegs[GATE_REG][7];

  // R2: key readback carries one status bit only
  p_key_narrow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (extRd && extIdx == IDX_KEY) |=> (extRdata[7:1] == 7'b0));

  // R3: closed port keeps offset A unchanged
  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> $stable(mapA));

  // R3: closed port blanks reads of ordinary registers
  p_locked_blank_r3: assert property (@(posedge clk) disable iff (!rstN)
    (extRd && !unlocked && extIdx == IDX_MAPA) |=> (extRdata == 8'h00));

  // R4: a write to the attribute register forces the phase flip-flop
  p_attr_force_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.attrWr |=> (attrFlip == $past(extWdata[7])));

  // R6: protected standard registers do not move
  p_std_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    hzProtect |=> $stable(stdFlat));

  // R6: gate bit frozen while register 0x11 bit 7 is set
  p_gate_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    cr11Reg[7] |=> $stable(stdRegs[GATE_REG][7]));

  // R7: page field frozen while its lock bit is set
  p_page_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    lockReg[PAGE_LOCK_BIT] |=> $stable(pageBits));

  // R8: with the select bit set only extension writes move the working copy
  p_shadow_path_r8: assert property (@(posedge clk) disable iff (!rstN)
    (shadowSel && !strobe.shExtWr) |=> $stable(hzWorking));

endmodule

// File: rtl/extbank_top.sv
module extbank_top
  import extbank_pkg::*;
#(
  parameter int NUM_STD    = 8,
  parameter int NUM_SHADOW = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    extWr,
  input  logic                    extRd,
  input  logic [7:0]              extIdx,
  input  logic [7:0]              extWdata,
  output logic [7:0]              extRdata,
  input  logic                    stdWr,
  input  logic                    stdRd,
  input  logic [7:0]              stdIdx,
  input  logic [7:0]              stdWdata,
  output logic [7:0]              stdRdata,
  input  logic                    attrToggle,
  output logic                    attrDataPhase,
  output logic [4:0]              attrIndex,
  output logic                    videoEnable,
  output logic [2:0]              pageCtl,
  output logic [7:0]              mapOffsetA,
  output logic [7:0]              mapOffsetB,
  output logic [NUM_SHADOW*8-1:0] hzWorking,
  output logic                    hzProtect
);

  bankStrobe_t strobe;
  bankStatus_t status;

  extbank_ctrl #(.NUM_STD(NUM_STD), .NUM_SHADOW(NUM_SHADOW)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .extWr    (extWr),
    .extIdx   (extIdx),
    .extWdata (extWdata),
    .stdWr    (stdWr),
    .stdIdx   (stdIdx),
    .status   (status),
    .strobe   (strobe)
  );

  extbank_dp #(.NUM_STD(NUM_STD), .NUM_SHADOW(NUM_SHADOW)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .extRd         (extRd),
    .extIdx        (extIdx),
    .extWdata      (extWdata),
    .stdRd         (stdRd),
    .stdIdx        (stdIdx),
    .stdWdata      (stdWdata),
    .attrToggle    (attrToggle),
    .status        (status),
    .extRdata      (extRdata),
    .stdRdata      (stdRdata),
    .attrDataPhase (attrDataPhase),
    .attrIndex     (attrIndex),
    .videoEnable   (videoEnable),
    .pageCtl       (pageCtl),
    .mapOffsetA    (mapOffsetA),
    .mapOffsetB    (mapOffsetB),
    .hzWorking     (hzWorking),
    .hzProtect     (hzProtect)
  );

endmodule

// File: tb/extbank_tb_top.sv
module extbank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SHADOW = 6;
  localparam int NV = 55;

  localparam logic [1:0] OP_EW = 2'd0;
  localparam logic [1:0] OP_ER = 2'd1;
  localparam logic [1:0] OP_SW = 2'd2;
  localparam logic [1:0] OP_SR = 2'd3;

  // {op, index, data-or-expected, requirement number}
  localparam logic [21:0] VECS [NV] = '{
    {OP_ER, 8'h0A, 8'h00, 4'd9},   // R9 key reads closed after reset
    {OP_EW, 8'h0E, 8'h55, 4'd3},   // R3 write while closed
    {OP_ER, 8'h0E, 8'h00, 4'd3},   // R3 read blanked
    {OP_EW, 8'h0A, 8'h12, 4'd1},   // R1 wrong key
    {OP_ER, 8'h0A, 8'h00, 4'd1},   // R1 still closed
    {OP_EW, 8'h0A, 8'hEC, 4'd1},   // R1 open
    {OP_ER, 8'h0A, 8'h01, 4'd2},   // R2 status bit
    {OP_ER, 8'h0E, 8'h00, 4'd3},   // R3 closed write had no effect
    {OP_EW, 8'h0E, 8'h55, 4'd10},  // R10
    {OP_ER, 8'h0E, 8'h55, 4'd10},  // R10
    {OP_EW, 8'h0F, 8'hA3, 4'd10},  // R10
    {OP_ER, 8'h0F, 8'hA3, 4'd10},  // R10
    {OP_ER, 8'h33, 8'h00, 4'd9},   // R9 unmapped
    {OP_EW, 8'h0B, 8'hE5, 4'd4},   // R4
    {OP_ER, 8'h0B, 8'hA5, 4'd4},   // R4 bit 6 reads zero
    {OP_EW, 8'h20, 8'h10, 4'd7},   // R7 lock page
    {OP_EW, 8'h0D, 8'h07, 4'd7},   // R7
    {OP_ER, 8'h0D, 8'h00, 4'd7},   // R7 ignored
    {OP_EW, 8'h20, 8'h00, 4'd7},   // R7 unlock page
    {OP_EW, 8'h0D, 8'h07, 4'd7},   // R7
    {OP_ER, 8'h0D, 8'h07, 4'd7},   // R7
    {OP_SW, 8'h00, 8'h5F, 4'd8},   // R8 tandem write
    {OP_SR, 8'h00, 8'h5F, 4'd8},   // R8
    {OP_ER, 8'h60, 8'h5F, 4'd8},   // R8 copy followed
    {OP_EW, 8'h21, 8'h01, 4'd8},   // R8 extension-only mode
    {OP_SW, 8'h01, 8'h40, 4'd8},   // R8
    {OP_SR, 8'h01, 8'h40, 4'd8},   // R8
    {OP_ER, 8'h61, 8'h00, 4'd8},   // R8 copy untouched
    {OP_EW, 8'h61, 8'h4F, 4'd8},   // R8
    {OP_ER, 8'h61, 8'h4F, 4'd8},   // R8
    {OP_SR, 8'h01, 8'h40, 4'd8},   // R8 standard untouched
    {OP_EW, 8'h21, 8'h00, 4'd8},   // R8
    {OP_SW, 8'h03, 8'h80, 4'd6},   // R6 gate bit on
    {OP_SW, 8'h11, 8'h80, 4'd6},   // R6 protect on
    {OP_SW, 8'h02, 8'h33, 4'd6},   // R6 blocked
    {OP_SR, 8'h02, 8'h00, 4'd6},   // R6
    {OP_ER, 8'h0C, 8'h80, 4'd5},   // R5 shared bit
    {OP_SW, 8'h11, 8'h00, 4'd6},   // R6 protect off
    {OP_SW, 8'h03, 8'h00, 4'd6},   // R6 gate off
    {OP_EW, 8'h0C, 8'h80, 4'd5},   // R5 deadlock state
    {OP_SW, 8'h03, 8'h85, 4'd6},   // R6 bit 7 held
    {OP_SR, 8'h03, 8'h05, 4'd6},   // R6
    {OP_SR, 8'h11, 8'h00, 4'd6},   // R6 unreachable
    {OP_SW, 8'h02, 8'h33, 4'd6},   // R6 not protected
    {OP_SR, 8'h02, 8'h33, 4'd6},   // R6
    {OP_EW, 8'h0C, 8'h00, 4'd5},   // R5 break deadlock
    {OP_SW, 8'h03, 8'h80, 4'd5},   // R5
    {OP_SR, 8'h03, 8'h80, 4'd5},   // R5 gate bit writable again
    {OP_EW, 8'h0A, 8'hCE, 4'd1},   // R1 close
    {OP_ER, 8'h0A, 8'h00, 4'd1},   // R1
    {OP_ER, 8'h0E, 8'h00, 4'd3},   // R3 blanked
    {OP_EW, 8'h0C, 8'h80, 4'd5},   // R5 writable while closed
    {OP_ER, 8'h0C, 8'h80, 4'd5},   // R5 readable while closed
    {OP_EW, 8'h0A, 8'hEC, 4'd1},   // R1 reopen
    {OP_ER, 8'h0E, 8'h55, 4'd3}    // R3 value retained
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extWr = 1'b0, extRd = 1'b0, stdWr = 1'b0, stdRd = 1'b0, attrToggle = 1'b0;
  logic [7:0] extIdx = '0, extWdata = '0, stdIdx = '0, stdWdata = '0;
  logic [7:0] extRdata, stdRdata, mapOffsetA, mapOffsetB;
  logic attrDataPhase, videoEnable, hzProtect;
  logic [4:0] attrIndex;
  logic [2:0] pageCtl;
  logic [NUM_SHADOW*8-1:0] hzWorking;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extbank_top #(.NUM_STD(8), .NUM_SHADOW(NUM_SHADOW)) dut_i (
    .clk(clk), .rstN(rstN),
    .extWr(extWr), .extRd(extRd), .extIdx(extIdx), .extWdata(extWdata), .extRdata(extRdata),
    .stdWr(stdWr), .stdRd(stdRd), .stdIdx(stdIdx), .stdWdata(stdWdata), .stdRdata(stdRdata),
    .attrToggle(attrToggle), .attrDataPhase(attrDataPhase), .attrIndex(attrIndex),
    .videoEnable(videoEnable), .pageCtl(pageCtl), .mapOffsetA(mapOffsetA),
    .mapOffsetB(mapOffsetB), .hzWorking(hzWorking), .hzProtect(hzProtect)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [7:0] idx, input logic [7:0] dat, input int req);
    @(negedge clk);
    case (op)
      OP_EW: begin extWr = 1'b1; extIdx = idx; extWdata = dat; end
      OP_ER: begin extRd = 1'b1; extIdx = idx; end
      OP_SW: begin stdWr = 1'b1; stdIdx = idx; stdWdata = dat; end
      default: begin stdRd = 1'b1; stdIdx = idx; end
    endcase
    @(negedge clk);
    extWr = 1'b0; extRd = 1'b0; stdWr = 1'b0; stdRd = 1'b0;
    if (op == OP_ER) check(extRdata, dat, req, $sformatf("ext read idx %02h", idx));
    if (op == OP_SR) check(stdRdata, dat, req, $sformatf("std read idx %02h", idx));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state at the ports (R9)
    check({7'b0, hzProtect}, 8'h00, 9, "R9 protect after reset");
    check(mapOffsetA, 8'h00, 9, "R9 offset A after reset");
    check({5'b0, pageCtl}, 8'h00, 9, "R9 page after reset");
    check(hzWorking[7:0], 8'h00, 9, "R9 copy0 after reset");

    for (int i = 0; i < NV; i++)
      access(VECS[i][21:20], VECS[i][19:12], VECS[i][11:4], int'(VECS[i][3:0]));

    // R4 side outputs and toggle input
    check({7'b0, attrDataPhase}, 8'h01, 4, "R4 phase output");
    check({7'b0, videoEnable}, 8'h01, 4, "R4 video enable");
    check({3'b0, attrIndex}, 8'h05, 4, "R4 attribute index");
    @(negedge clk); attrToggle = 1'b1;
    @(negedge clk); attrToggle = 1'b0;
    check({7'b0, attrDataPhase}, 8'h00, 4, "R4 toggle inverts");
    access(OP_ER, 8'h0B, 8'h25, 4);   // R4 readback after toggle
    check(mapOffsetA, 8'h55, 10, "R10 offset A output");
    check(mapOffsetB, 8'hA3, 10, "R10 offset B output");
    check(hzWorking[7:0], 8'h5F, 8, "R8 copy0 output");
    check(hzWorking[15:8], 8'h4F, 8, "R8 copy1 output");
    check({5'b0, pageCtl}, 8'h07, 7, "R7 page output");
    check({7'b0, hzProtect}, 8'h01, 6, "R6 protect output");

    // R9 reset mid-run
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    check(mapOffsetA, 8'h00, 9, "R9 offset A cleared");
    check(hzWorking[15:8], 8'h00, 9, "R9 copy1 cleared");
    check({7'b0, attrDataPhase}, 8'h00, 9, "R9 phase cleared");
    check({7'b0, hzProtect}, 8'h00, 9, "R9 protect cleared");
    access(OP_ER, 8'h0A, 8'h00, 9);   // R9 port closed again
    access(OP_EW, 8'h0F, 8'h77, 3);   // R3 closed after reset
    check(mapOffsetB, 8'h00, 3, "R3 offset B unchanged while closed");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule